// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block produces data memory addresses for a processor datapath. It keeps four 16-bit pointers. Each pointer has its own start register and its own span register, which together describe a circular buffer. Four signed step registers hold the amounts a pointer can move by. Each access request names a pointer, a step register and an ordering. The block sends out a 24-bit address whose top eight bits come from a page register. In the same clock edge it writes the moved pointer back.

When a pointer's span is zero, the pointer moves linearly and wraps at 16 bits. When the span is nonzero, the pointer is held inside the window [start, start+span-1]. No movement ever carries into the page bits.

All registers exist twice, in a primary bank and a secondary bank. A single select input decides which bank is live, so a context switch costs nothing. A host port writes and reads the registers of the live bank.

Top module: `dag_addr_gen`

## Requirements
- R1: After a synchronous reset, every pointer, step, start, span and page register in both banks is zero, `addr_out` is zero and `addr_valid` is low.
- R2: For an access with `acc_pre`=0 (after-move), `addr_out` carries the pointer value from before the access, and the pointer then holds the moved value.
- R3: For an access with `acc_pre`=1 (before-move), `addr_out` carries the moved value, and the pointer also keeps that moved value.
- R4: With a nonzero span, a non-negative step that takes the pointer to start+span or beyond subtracts the span, keeping the pointer inside the window.
- R5: With a nonzero span, a negative step that takes the pointer below start adds the span.
- R6: With a span of zero, the pointer moves by the signed step modulo 2^16.
- R7: `addr_out[23:16]` is the live bank's page register and `addr_out[15:0]` is the pointer value. A pointer move never changes the page bits.
- R8: `bank_sel` picks the live bank (0 = primary, 1 = secondary). Accesses, host writes and host reads touch only the live bank, and the other bank keeps its contents.
- R9: `addr_out` and `addr_valid` are registered. They show the result of an access one clock after `acc_valid` is sampled high, and `addr_valid` is low one clock after `acc_valid` is sampled low.
- R10: A host write takes effect at the clock edge where `wr_en` is sampled high. `rd_data` shows the addressed register one clock after the read select is sampled. The register kind codes are 0 pointer, 1 step, 2 start, 3 span and 4 page, and the page is zero-extended on `rd_data`.
- R11: When a host write to a pointer and an access to the same pointer occur in the same cycle, the host write decides the pointer's new value. The address still uses the old pointer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 1 | Live register bank: 0 primary, 1 secondary |
| wr_en | input | 1 | Host register write strobe |
| wr_kind | input | 3 | Register kind for write (0 pointer, 1 step, 2 start, 3 span, 4 page) |
| wr_sel | input | 2 | Register number within the kind |
| wr_data | input | 16 | Write data (page uses the low 8 bits) |
| rd_kind | input | 3 | Register kind for read |
| rd_sel | input | 2 | Register number for read |
| rd_data | output | 16 | Registered read data |
| acc_valid | input | 1 | Access request |
| acc_ptr | input | 2 | Pointer used by the access |
| acc_step | input | 2 | Step register used by the access |
| acc_pre | input | 1 | 1 = emit moved value, 0 = emit old value |
| addr_out | output | 24 | Registered data address {page, pointer} |
| addr_valid | output | 1 | Registered access-valid flag |

## Verification
Each output is due exactly one clock after its stimulus. An access request or a read select that is sampled at a rising edge shows up on `addr_out`, `addr_valid` or `rd_data` right after that same edge. A host write is visible to an access or read in the following cycle. The bench drives inputs on the falling edge and samples one nanosecond after the rising edge that registers the result, so every comparison lands in the first cycle the new value is due. Pointer write-back is confirmed by the address of the next access or by a host read issued afterwards, never in the cycle of the access itself.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [2:0] {
    RK_POINTER = 3'd0,
    RK_STEP    = 3'd1,
    RK_START   = 3'd2,
    RK_SPAN    = 3'd3,
    RK_PAGE    = 3'd4
  } reg_kind_e;
endpackage

// File: rtl/dag_modulo_step.sv
module dag_modulo_step #(
  parameter int IDX_W = 16
) (
  input  logic [IDX_W-1:0] cur_idx,
  input  logic [IDX_W-1:0] step,
  input  logic [IDX_W-1:0] start,
  input  logic [IDX_W-1:0] span,
  output logic [IDX_W-1:0] nxt_idx
);
  localparam int EXT_W = IDX_W + 2;

  logic [EXT_W-1:0] sum_ext;
  logic [EXT_W-1:0] lim_ext;
  logic [EXT_W-1:0] start_ext;
  logic [EXT_W-1:0] span_ext;
  logic [EXT_W-1:0] res_ext;
  logic             step_neg;

  always_comb begin
    step_neg  = step[IDX_W-1];
    start_ext = {2'b00, start};
    span_ext  = {2'b00, span};
    sum_ext   = {2'b00, cur_idx} + {{2{step[IDX_W-1]}}, step};
    lim_ext   = start_ext + span_ext;
    res_ext   = sum_ext;
    if (span != '0) begin
      if (!step_neg && (sum_ext >= lim_ext)) begin
        res_ext = sum_ext - span_ext;
      end else if (step_neg && (sum_ext[EXT_W-1] || (sum_ext < start_ext))) begin
        res_ext = sum_ext + span_ext;
      end
    end
    nxt_idx = res_ext[IDX_W-1:0];
  end
endmodule

// File: rtl/dag_regfile.sv
module dag_regfile
  import dag_pkg::*;
#(
  parameter int IDX_W   = 16,
  parameter int PAGE_W  = 8,
  parameter int NUM_PTR = 4,
  parameter int NUM_BNK = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bank_sel,
  input  logic                       wr_en,
  input  logic [2:0]                 wr_kind,
  input  logic [$clog2(NUM_PTR)-1:0] wr_sel,
  input  logic [IDX_W-1:0]           wr_data,
  input  logic [2:0]                 rd_kind,
  input  logic [$clog2(NUM_PTR)-1:0] rd_sel,
  output logic [IDX_W-1:0]           rd_data,
  input  logic                       upd_en,
  input  logic [$clog2(NUM_PTR)-1:0] upd_ptr,
  input  logic [IDX_W-1:0]           upd_val,
  input  logic [$clog2(NUM_PTR)-1:0] q_ptr,
  input  logic [$clog2(NUM_PTR)-1:0] q_step,
  output logic [IDX_W-1:0]           q_idx,
  output logic [IDX_W-1:0]           q_stepv,
  output logic [IDX_W-1:0]           q_start,
  output logic [IDX_W-1:0]           q_span,
  output logic [PAGE_W-1:0]          q_page
);
  logic [IDX_W-1:0]  ptr_q   [NUM_BNK][NUM_PTR];
  logic [IDX_W-1:0]  step_q  [NUM_BNK][NUM_PTR];
  logic [IDX_W-1:0]  start_q [NUM_BNK][NUM_PTR];
  logic [IDX_W-1:0]  span_q  [NUM_BNK][NUM_PTR];
  logic [PAGE_W-1:0] page_q  [NUM_BNK];

  reg_kind_e wk, rk;
  assign wk = reg_kind_e'(wr_kind);
  assign rk = reg_kind_e'(rd_kind);

  for (genvar b = 0; b < NUM_BNK; b++) begin : g_bank
    for (genvar p = 0; p < NUM_PTR; p++) begin : g_ptr
      logic bank_hit, w_hit;
      assign bank_hit = (int'(bank_sel) == b);
      assign w_hit    = wr_en && bank_hit && (int'(wr_sel) == p);

      always_ff @(posedge clk) begin
        if (rst) begin
          ptr_q[b][p]   <= '0;
          step_q[b][p]  <= '0;
          start_q[b][p] <= '0;
          span_q[b][p]  <= '0;
        end else begin
          if (w_hit && wk == RK_POINTER) begin
            ptr_q[b][p] <= wr_data;
          end else if (upd_en && bank_hit && int'(upd_ptr) == p) begin
            ptr_q[b][p] <= upd_val;
          end
          if (w_hit && wk == RK_STEP)  step_q[b][p]  <= wr_data;
          if (w_hit && wk == RK_START) start_q[b][p] <= wr_data;
          if (w_hit && wk == RK_SPAN)  span_q[b][p]  <= wr_data;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        page_q[b] <= '0;
      end else if (wr_en && int'(bank_sel) == b && wk == RK_PAGE) begin
        page_q[b] <= wr_data[PAGE_W-1:0];
      end
    end
  end

  always_comb begin
    q_idx   = ptr_q[bank_sel][q_ptr];
    q_stepv = step_q[bank_sel][q_step];
    q_start = start_q[bank_sel][q_ptr];
    q_span  = span_q[bank_sel][q_ptr];
    q_page  = page_q[bank_sel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rk)
        RK_POINTER: rd_data <= ptr_q[bank_sel][rd_sel];
        RK_STEP:    rd_data <= step_q[bank_sel][rd_sel];
        RK_START:   rd_data <= start_q[bank_sel][rd_sel];
        RK_SPAN:    rd_data <= span_q[bank_sel][rd_sel];
        RK_PAGE:    rd_data <= {{(IDX_W-PAGE_W){1'b0}}, page_q[bank_sel]};
        default:    rd_data <= '0;
      endcase
    end
  end

  // R10
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(page_q[0]) && $stable(page_q[1])));

  // R8
  idle_bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!bank_sel && !rst) |=> $stable(page_q[1]) || $past(rst));
endmodule

// File: rtl/dag_addr_gen.sv
module dag_addr_gen #(
  parameter int IDX_W   = 16,
  parameter int PAGE_W  = 8,
  parameter int NUM_PTR = 4,
  parameter int NUM_BNK = 2,
  localparam int SEL_W  = $clog2(NUM_PTR),
  localparam int ADDR_W = IDX_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bank_sel,
  input  logic              wr_en,
  input  logic [2:0]        wr_kind,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [IDX_W-1:0]  wr_data,
  input  logic [2:0]        rd_kind,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [IDX_W-1:0]  rd_data,
  input  logic              acc_valid,
  input  logic [SEL_W-1:0]  acc_ptr,
  input  logic [SEL_W-1:0]  acc_step,
  input  logic              acc_pre,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_valid
);
  logic [IDX_W-1:0]  cur_idx, cur_step, cur_start, cur_span, nxt_idx;
  logic [PAGE_W-1:0] cur_page;

  dag_regfile #(
    .IDX_W(IDX_W), .PAGE_W(PAGE_W), .NUM_PTR(NUM_PTR), .NUM_BNK(NUM_BNK)
  ) u_regs (
    .clk(clk), .rst(rst), .bank_sel(bank_sel),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_kind(rd_kind), .rd_sel(rd_sel), .rd_data(rd_data),
    .upd_en(acc_valid), .upd_ptr(acc_ptr), .upd_val(nxt_idx),
    .q_ptr(acc_ptr), .q_step(acc_step),
    .q_idx(cur_idx), .q_stepv(cur_step), .q_start(cur_start),
    .q_span(cur_span), .q_page(cur_page)
  );

  dag_modulo_step #(.IDX_W(IDX_W)) u_step (
    .cur_idx(cur_idx), .step(cur_step), .start(cur_start),
    .span(cur_span), .nxt_idx(nxt_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out   <= '0;
      addr_valid <= 1'b0;
    end else begin
      addr_valid <= acc_valid;
      if (acc_valid) begin
        addr_out <= {cur_page, (acc_pre ? nxt_idx : cur_idx)};
      end
    end
  end

  // R9
  valid_lag_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (addr_valid == $past(acc_valid)));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!addr_valid && addr_out == '0));

  // R7
  page_bits_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> (addr_out[ADDR_W-1:IDX_W] == $past(cur_page)));

  // R4
  window_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && cur_span != '0 && cur_idx >= cur_start &&
     ({1'b0, cur_idx} < ({1'b0, cur_start} + {1'b0, cur_span})))
    |-> (nxt_idx >= cur_start &&
         ({1'b0, nxt_idx} < ({1'b0, cur_start} + {1'b0, cur_span}))));
endmodule

// File: tb/dag_addr_gen_tb.sv
module dag_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bank_sel = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_kind = '0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_kind = '0;
  logic [1:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_ptr = '0;
  logic [1:0]  acc_step = '0;
  logic        acc_pre = 1'b0;
  logic [23:0] addr_out;
  logic        addr_valid;

  int n_run = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dag_addr_gen u_dut (
    .clk(clk), .rst(rst), .bank_sel(bank_sel),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_kind(rd_kind), .rd_sel(rd_sel), .rd_data(rd_data),
    .acc_valid(acc_valid), .acc_ptr(acc_ptr), .acc_step(acc_step),
    .acc_pre(acc_pre), .addr_out(addr_out), .addr_valid(addr_valid)
  );

  // {ptr[2], step[2], pre[1], expected address[24]}
  localparam logic [28:0] VEC [0:10] = '{
    {2'd0, 2'd0, 1'b0, 24'h120100},  // R2 after-move
    {2'd0, 2'd0, 1'b0, 24'h120102},  // R2
    {2'd0, 2'd0, 1'b0, 24'h120104},  // R4 next wraps to 0x101
    {2'd0, 2'd1, 1'b1, 24'h120103},  // R5 + R3 backward wrap
    {2'd0, 2'd0, 1'b1, 24'h120100},  // R4 + R3 forward wrap
    {2'd1, 2'd2, 1'b0, 24'h12FFFF},  // R6 linear
    {2'd1, 2'd2, 1'b0, 24'h120000},  // R6 + R7 wrap without carry
    {2'd1, 2'd1, 1'b1, 24'h12FFFE},  // R6 negative linear
    {2'd2, 2'd3, 1'b0, 24'h12FFFE},  // R7 window at page top
    {2'd2, 2'd3, 1'b0, 24'h12FFFD},  // R4 wrap instead of carry
    {2'd2, 2'd3, 1'b1, 24'h12FFFF}   // R3 + R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] k, input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = k; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] k, input logic [1:0] s, input logic [15:0] exp);
    @(negedge clk);
    rd_kind = k; rd_sel = s;
    @(posedge clk); #1;
    check(req, {16'h0, rd_data}, {16'h0, exp});
  endtask

  task automatic acc(input string req, input logic [1:0] p, input logic [1:0] m,
                     input logic pre, input logic [23:0] exp);
    @(negedge clk);
    acc_valid = 1'b1; acc_ptr = p; acc_step = m; acc_pre = pre;
    @(posedge clk); #1;
    acc_valid = 1'b0;
    check(req, {8'h0, addr_out}, {8'h0, exp});
    check("R9 valid", {31'h0, addr_valid}, 32'h1);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_run++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 addr", {8'h0, addr_out}, 32'h0);
    check("R1 valid", {31'h0, addr_valid}, 32'h0);
    @(negedge clk); rst = 1'b0;
    rd("R1 pointer0", 3'd0, 2'd0, 16'h0000);
    rd("R1 page", 3'd4, 2'd0, 16'h0000);

    // primary bank setup (R10 kind codes)
    wr(3'd0, 2'd0, 16'h0100); wr(3'd2, 2'd0, 16'h0100); wr(3'd3, 2'd0, 16'd5);
    wr(3'd1, 2'd0, 16'd2);    wr(3'd1, 2'd1, 16'hFFFD); wr(3'd1, 2'd2, 16'd1);
    wr(3'd0, 2'd1, 16'hFFFF);
    wr(3'd0, 2'd2, 16'hFFFE); wr(3'd2, 2'd2, 16'hFFFC); wr(3'd3, 2'd2, 16'd4);
    wr(3'd1, 2'd3, 16'd3);    wr(3'd4, 2'd0, 16'h0012);
    rd("R10 start readback", 3'd2, 2'd2, 16'hFFFC);
    rd("R10 page readback", 3'd4, 2'd0, 16'h0012);

    for (int i = 0; i < 11; i++) begin
      acc($sformatf("vec%0d", i), VEC[i][28:27], VEC[i][26:25], VEC[i][24], VEC[i][23:0]);
    end
    rd("R2 pointer0 stored", 3'd0, 2'd0, 16'h0100);
    rd("R4 pointer2 stored", 3'd0, 2'd2, 16'hFFFF);

    // R9: valid drops one cycle after idle
    @(posedge clk); #1;
    check("R9 idle", {31'h0, addr_valid}, 32'h0);

    // R11: host write wins against same-cycle access
    @(negedge clk);
    wr_en = 1'b1; wr_kind = 3'd0; wr_sel = 2'd3; wr_data = 16'h0500;
    acc_valid = 1'b1; acc_ptr = 2'd3; acc_step = 2'd0; acc_pre = 1'b0;
    @(posedge clk); #1;
    wr_en = 1'b0; acc_valid = 1'b0;
    check("R11 addr", {8'h0, addr_out}, 32'h00120000);
    rd("R11 pointer3", 3'd0, 2'd3, 16'h0500);

    // R8: secondary bank
    @(negedge clk); bank_sel = 1'b1;
    rd("R8 secondary pointer0", 3'd0, 2'd0, 16'h0000);
    wr(3'd4, 2'd0, 16'h00AB); wr(3'd0, 2'd0, 16'h0040); wr(3'd1, 2'd0, 16'd1);
    acc("R8 secondary access", 2'd0, 2'd0, 1'b0, 24'hAB0040);
    rd("R8 secondary pointer moved", 3'd0, 2'd0, 16'h0041);
    @(negedge clk); bank_sel = 1'b0;
    rd("R8 primary pointer kept", 3'd0, 2'd0, 16'h0100);
    rd("R8 primary page kept", 3'd4, 2'd0, 16'h0012);
    acc("R8 primary access", 2'd0, 2'd0, 1'b0, 24'h120100);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule